// File: doc/BRIEF.md
# Bridge memory window forwarding decoder

This block decides, for a two-port bus bridge, which memory transactions cross the bridge through its non-prefetchable (memory-mapped I/O) window. It keeps a 16-bit window base register and a 16-bit window limit register, reachable through a small configuration port that has an offset, write data, byte enables and read data. The upper twelve bits of each register give address bits [31:20]. The base is taken to end in 0x00000 and the limit to end in 0xFFFFF, so the window always covers whole 1MB blocks.

Each cycle the block compares the address presented on each side against the window. On the primary side, a memory transaction that lands inside the window is claimed for downstream forwarding. On the secondary side, a memory transaction that lands outside the window is claimed for upstream forwarding, unless the external prefetchable-window decoder or the legacy-video decoder has already taken it. Each direction has its own command enable bit, which gates it. A separate flag marks a plain memory read claimed downstream, so that it is held to one data phase. All decode outputs are combinational. Configuration writes take effect at the clock edge on which the write strobe is sampled.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset, a configuration read at offset 0x20 returns 0x0000_0000, which means base register 0x0000 and limit register 0x0000. The effective window is 0x0000_0000 to 0x000F_FFFF.
- R2: A write at offset 0x20 updates base bits [7:0] from wdata[7:0] when be[0] is set, base bits [15:8] from wdata[15:8] when be[1] is set, limit bits [7:0] from wdata[23:16] when be[2] is set, and limit bits [15:8] from wdata[31:24] when be[3] is set. The update is visible from the next clock edge. Bits [3:0] of both registers always read 0. A read at 0x20 returns {limit, base}.
- R3: A primary memory transaction with a 32-bit address A, where {base[15:4],20'h00000} <= A <= {limit[15:4],20'hFFFFF}, asserts p_claim when mem_en is 1. A primary address outside that range leaves p_claim at 0.
- R4: p_claim stays 0 while mem_en is 0.
- R5: A secondary memory transaction inside the window leaves s_claim at 0. A secondary memory transaction outside the window asserts s_claim when master_en is 1.
- R6: s_claim stays 0 when master_en is 0, when s_pf_hit is 1, or when s_vga_hit is 1.
- R7: A dual-address cycle (p_dac or s_dac set to 1) never hits the window. p_claim stays 0, and on the secondary side the cycle counts as outside the window.
- R8: p_single is 1 exactly when p_claim is 1 and the command is memory read (code 4'h6). Memory write (4'h7), read multiple (4'hC) and read line (4'hE) do not set it.
- R9: When the effective base is above the effective limit, no primary address is claimed, and every secondary address counts as outside the window.
- R10: Commands other than the memory codes 4'h6, 4'h7, 4'hC, 4'hE and 4'hF are never claimed on either side. Writes to any offset other than 0x20 leave both registers unchanged, and reads at other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_rdata | output | 32 | Configuration read data |
| mem_en | input | 1 | Command memory-enable bit, gates downstream forwarding |
| master_en | input | 1 | Command master-enable bit, gates upstream forwarding |
| p_valid | input | 1 | Primary-side transaction present |
| p_cmd | input | 4 | Primary-side bus command code |
| p_dac | input | 1 | Primary-side dual-address cycle |
| p_addr | input | 32 | Primary-side address |
| p_claim | output | 1 | Forward the primary transaction downstream |
| p_single | output | 1 | Limit the claimed primary read to one data phase |
| s_valid | input | 1 | Secondary-side transaction present |
| s_cmd | input | 4 | Secondary-side bus command code |
| s_dac | input | 1 | Secondary-side dual-address cycle |
| s_addr | input | 32 | Secondary-side address |
| s_pf_hit | input | 1 | External prefetchable-window decode hit |
| s_vga_hit | input | 1 | External legacy-video decode hit |
| s_claim | output | 1 | Forward the secondary transaction upstream |

## Verification
The hardest states to reach from the ports are the exact 1MB edges of a window that was built from partial byte-enable writes. The bench reaches them by writing all four bytes first and then changing a single limit byte, and it probes addresses one step below the base and one step above the limit. It also reaches the empty-window case by writing a base above the limit. It then confirms that primary claims stop while secondary claims cover the addresses between the two values.

// File: rtl/mem_window_decoder.sv
module mem_window_decoder #(
  parameter logic [7:0] CFG_OFFSET = 8'h20,
  parameter int         GRAN_BITS  = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  input  logic        mem_en,
  input  logic        master_en,
  input  logic        p_valid,
  input  logic [3:0]  p_cmd,
  input  logic        p_dac,
  input  logic [31:0] p_addr,
  output logic        p_claim,
  output logic        p_single,
  input  logic        s_valid,
  input  logic [3:0]  s_cmd,
  input  logic        s_dac,
  input  logic [31:0] s_addr,
  input  logic        s_pf_hit,
  input  logic        s_vga_hit,
  output logic        s_claim
);
  localparam int TOP_W = 32 - GRAN_BITS;
  localparam int LSB   = 16 - TOP_W;

  logic [TOP_W-1:0] win_lo, win_hi;
  logic             sel, p_in, s_in, p_mem, s_mem;

  function automatic logic is_mem(input logic [3:0] c);
    return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
  endfunction

  assign sel = cfg_addr[7:2] == CFG_OFFSET[7:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_lo <= '0;
      win_hi <= '0;
    end else if (cfg_wr && sel) begin
      if (cfg_be[0]) win_lo[7-LSB:0]      <= cfg_wdata[7:LSB];
      if (cfg_be[1]) win_lo[TOP_W-1:8-LSB] <= cfg_wdata[15:8];
      if (cfg_be[2]) win_hi[7-LSB:0]      <= cfg_wdata[23:16+LSB];
      if (cfg_be[3]) win_hi[TOP_W-1:8-LSB] <= cfg_wdata[31:24];
    end
  end

  assign cfg_rdata = sel ? {win_hi, {LSB{1'b0}}, win_lo, {LSB{1'b0}}} : 32'h0;

  assign p_in  = !p_dac && p_addr[31:GRAN_BITS] >= win_lo && p_addr[31:GRAN_BITS] <= win_hi;
  assign s_in  = !s_dac && s_addr[31:GRAN_BITS] >= win_lo && s_addr[31:GRAN_BITS] <= win_hi;
  assign p_mem = p_valid && is_mem(p_cmd);
  assign s_mem = s_valid && is_mem(s_cmd);

  assign p_claim  = p_mem && mem_en && p_in;
  assign p_single = p_claim && p_cmd == 4'h6;
  assign s_claim  = s_mem && master_en && !s_in && !s_pf_hit && !s_vga_hit;

  // R4
  p_claim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_claim |-> mem_en && p_valid);
  // R6
  s_claim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_claim |-> master_en && !s_pf_hit && !s_vga_hit);
  // R7
  p_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_dac |-> !p_claim);
  // R8
  p_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_single |-> p_claim && p_cmd == 4'h6);
  // R2
  hi_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == CFG_OFFSET && cfg_be[3]
    |=> cfg_addr != CFG_OFFSET || cfg_rdata[31:24] == $past(cfg_wdata[31:24]));
  // R10
  other_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr[7:2] != CFG_OFFSET[7:2] |=> $stable(win_lo) && $stable(win_hi));
endmodule

// File: tb/mem_window_decoder_test.sv
module mem_window_decoder_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 8'h20;
  logic [31:0] cfg_wdata = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_rdata;
  logic mem_en = 0, master_en = 0;
  logic p_valid = 0, p_dac = 0, s_valid = 0, s_dac = 0, s_pf_hit = 0, s_vga_hit = 0;
  logic [3:0] p_cmd = 0, s_cmd = 0;
  logic [31:0] p_addr = 0, s_addr = 0;
  logic p_claim, p_single, s_claim;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_window_decoder uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_addr = 8'h20;
  endtask

  task automatic cfg_read(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    chk(req, cfg_rdata, exp);
    cfg_addr = 8'h20;
  endtask

  task automatic prim(string req, logic [3:0] c, logic dac, logic [31:0] a, logic ec, logic es);
    @(negedge clk);
    p_valid = 1; p_cmd = c; p_dac = dac; p_addr = a; #1;
    chk({req, " p_claim"}, p_claim, ec);
    chk({req, " p_single"}, p_single, es);
    p_valid = 0; p_dac = 0;
  endtask

  task automatic sec(string req, logic [3:0] c, logic dac, logic [31:0] a, logic pf, logic vga, logic ec);
    @(negedge clk);
    s_valid = 1; s_cmd = c; s_dac = dac; s_addr = a; s_pf_hit = pf; s_vga_hit = vga; #1;
    chk({req, " s_claim"}, s_claim, ec);
    s_valid = 0; s_dac = 0; s_pf_hit = 0; s_vga_hit = 0;
  endtask

  task automatic test_reset();
    cfg_read("R1", 8'h20, 32'h0);
    mem_en = 1;
    prim("R1", 4'h6, 0, 32'h000F_FFFF, 1, 1);
    prim("R1", 4'h6, 0, 32'h0010_0000, 0, 0);
  endtask

  task automatic test_config();
    cfg_write(8'h20, 32'h2345_1237, 4'hF);
    cfg_read("R2", 8'h20, 32'h2340_1230);
    cfg_write(8'h20, 32'h00AB_0000, 4'h4);
    cfg_read("R2", 8'h20, 32'h23A0_1230);
    cfg_write(8'h24, 32'hFFFF_FFFF, 4'hF);
    cfg_read("R10", 8'h20, 32'h23A0_1230);
    cfg_read("R10", 8'h24, 32'h0);
  endtask

  task automatic test_primary();
    mem_en = 1;
    prim("R3", 4'h7, 0, 32'h1230_0000, 1, 0);
    prim("R3", 4'h7, 0, 32'h122F_FFFF, 0, 0);
    prim("R3", 4'h7, 0, 32'h23AF_FFFF, 1, 0);
    prim("R3", 4'h7, 0, 32'h23B0_0000, 0, 0);
    prim("R8", 4'h6, 0, 32'h2000_0000, 1, 1);
    prim("R8", 4'hC, 0, 32'h2000_0000, 1, 0);
    prim("R8", 4'hE, 0, 32'h2000_0000, 1, 0);
    prim("R10", 4'h2, 0, 32'h2000_0000, 0, 0);
    prim("R7", 4'h6, 1, 32'h2000_0000, 0, 0);
    mem_en = 0;
    prim("R4", 4'h6, 0, 32'h2000_0000, 0, 0);
    mem_en = 1;
  endtask

  task automatic test_secondary();
    master_en = 1;
    sec("R5", 4'h7, 0, 32'h2000_0000, 0, 0, 0);
    sec("R5", 4'h7, 0, 32'h4000_0000, 0, 0, 1);
    sec("R5", 4'h6, 0, 32'h122F_FFFF, 0, 0, 1);
    sec("R6", 4'h7, 0, 32'h4000_0000, 1, 0, 0);
    sec("R6", 4'h7, 0, 32'h4000_0000, 0, 1, 0);
    sec("R7", 4'h7, 1, 32'h2000_0000, 0, 0, 1);
    sec("R10", 4'h3, 0, 32'h4000_0000, 0, 0, 0);
    master_en = 0;
    sec("R6", 4'h7, 0, 32'h4000_0000, 0, 0, 0);
    master_en = 1;
  endtask

  task automatic test_empty();
    cfg_write(8'h20, 32'h4000_5000, 4'hF);
    cfg_read("R9", 8'h20, 32'h4000_5000);
    prim("R9", 4'h7, 0, 32'h4500_0000, 0, 0);
    prim("R9", 4'h7, 0, 32'h5000_0000, 0, 0);
    prim("R9", 4'h7, 0, 32'h4000_0000, 0, 0);
    sec("R9", 4'h7, 0, 32'h4500_0000, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_config();
    test_primary();
    test_secondary();
    test_empty();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule